// File: doc/BRIEF.md
# Port Interrupt Status and Steering Unit

This unit collects event pulses from several storage ports and keeps them as sticky interrupt status. For each port it holds a twelve-bit event latch, a matching enable mask and a two-bit steering field. It also holds a mode bit that selects how software acknowledges events. Every status read returns two views of the same latch: the events gated by their enables and the raw events. A host-level register reports which ports have an enabled event pending. A host enable mask decides which of those ports drive the single interrupt line.

Software reaches the unit through a simple register port. A write strobe or a read strobe is applied together with an address. Read data is registered and appears on the cycle after the read strobe. Address bit 15 selects between the host region (1) and the port region (0). In the port region, bits [14:13] hold the port index, so the port stride is 0x2000, and bits [12:0] give the offset inside the port. Event inputs are single-cycle pulses, grouped twelve bits per port, with port p at bits [12p+11:12p].

Top module: `pirq_hub`

## Requirements
- R1: A pulse on event bit k of a port sets raw bit k of that port on the next clock edge. The bit stays set until it is cleared. Bit meanings: 0 command done, 1 command error, 2 port-ready change, 3 power change, 4 PHY-ready change, 5 wake signal received, 6 unknown frame received, 11 set-device-bits frame received.
- R2: A read of port offset 0x1008 returns the raw bits ANDed with the enables in bits [11:0] and the raw bits in bits [27:16]. All other bits read as 0. Read data appears one cycle after the read strobe.
- R3: A write to offset 0x1010 sets every enable bit whose data bit [11:0] is 1. A write to offset 0x1014 clears every enable bit whose data bit [11:0] is 1. A read of 0x1010 returns the enables in [11:0] and the steering field in [31:30]. A read of 0x1014 returns 0.
- R4: A write to 0x1010 whose data bits [31:30] are nonzero loads the steering field from those bits; if they are zero, the field is left unchanged. A write to 0x1014 clears each steering bit whose data bit [31:30] is 1.
- R5: The acknowledge mode bit sits at bit 3 of offset 0x1000. Writing a 1 there to 0x1000 sets it, writing a 1 there to 0x1004 clears it, and reading 0x1000 returns it. While the bit is 1, a write to 0x1008 clears each raw bit k for which data bit k or data bit k+16 is 1.
- R6: While the mode bit is 0, writes to 0x1008 have no effect. Instead, a read of 0x1008 clears the raw bits that this read returned.
- R7: An event pulse on a bit in the same cycle as a clear of that bit, by write or by read, leaves the bit set.
- R8: A read of offset 0x1800 returns the latched command-error event (raw bit 1) in bit 31, with all other bits 0.
- R9: A read of host offset 0x44 (address 0x8044) returns in bit p whether port p has any enabled raw bit set.
- R10: Host offset 0x40 (address 0x8040) is a per-port interrupt enable in bits [3:0], readable and writable. irq_o is registered: one cycle after a change, it equals the OR over ports of (pending bit AND host enable).
- R11: After reset, all latches, enables, steering fields and host enables are 0, irq_o is 0, and every port's mode bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid one cycle after reg_re |
| evt_in | input | 48 | Event pulses, 12 per port |
| irq_o | output | 1 | Host interrupt request |

## Verification
Two pairs of actions can land on the same edge. In the first, an event pulse can arrive in the cycle that software clears the same status bit, whether by a one-written acknowledge or by a clearing read. In the second, a read that returns a bit can coincide with a fresh event on that bit. The bench drives the event pulse and the register strobe in one cycle, then reads the status word twice. The first read must show the bit still set; in clear-on-read mode, that read clears it, so the second read must show it gone.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int EVT_W     = 12;
  localparam int RAW_SHIFT = 16;
  localparam int DATA_W    = 32;
  localparam int OFS_W     = 13;

  localparam logic [OFS_W-1:0] OFS_CTRL_SET = 13'h1000;
  localparam logic [OFS_W-1:0] OFS_CTRL_CLR = 13'h1004;
  localparam logic [OFS_W-1:0] OFS_STAT     = 13'h1008;
  localparam logic [OFS_W-1:0] OFS_EN_SET   = 13'h1010;
  localparam logic [OFS_W-1:0] OFS_EN_CLR   = 13'h1014;
  localparam logic [OFS_W-1:0] OFS_SLOT     = 13'h1800;
  localparam logic [OFS_W-1:0] OFS_HOST_EN  = 13'h0040;
  localparam logic [OFS_W-1:0] OFS_HOST_ST  = 13'h0044;

  localparam int MODE_BIT  = 3;
  localparam int ERR_BIT   = 1;
  localparam int STEER_LSB = 30;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTRL_SET, RS_CTRL_CLR, RS_STAT, RS_EN_SET, RS_EN_CLR, RS_SLOT
  } port_reg_e;

  function automatic port_reg_e decode_port(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_CTRL_SET: decode_port = RS_CTRL_SET;
      OFS_CTRL_CLR: decode_port = RS_CTRL_CLR;
      OFS_STAT:     decode_port = RS_STAT;
      OFS_EN_SET:   decode_port = RS_EN_SET;
      OFS_EN_CLR:   decode_port = RS_EN_CLR;
      OFS_SLOT:     decode_port = RS_SLOT;
      default:      decode_port = RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pirq_port_regs.sv
module pirq_port_regs
  import pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic              re,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evt,
  output logic [DATA_W-1:0] rdata,
  output logic              pending
);
  port_reg_e        rsel;
  logic [EVT_W-1:0] raw_q, en_q, clr_mask, masked;
  logic [1:0]       steer_q;
  logic             mode_q;
  logic             acc_w, acc_r;

  assign rsel   = decode_port(ofs);
  assign acc_w  = sel && we;
  assign acc_r  = sel && re;
  assign masked = raw_q & en_q;
  assign pending = |masked;

  always_comb begin
    clr_mask = '0;
    if (acc_w && rsel == RS_STAT && mode_q)
      clr_mask = wdata[EVT_W-1:0] | wdata[RAW_SHIFT +: EVT_W];
    else if (acc_r && rsel == RS_STAT && !mode_q)
      clr_mask = raw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= (raw_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      steer_q <= '0;
      mode_q  <= 1'b1;
    end else if (acc_w) begin
      case (rsel)
        RS_EN_SET: begin
          en_q <= en_q | wdata[EVT_W-1:0];
          if (|wdata[STEER_LSB +: 2]) steer_q <= wdata[STEER_LSB +: 2];
        end
        RS_EN_CLR: begin
          en_q    <= en_q & ~wdata[EVT_W-1:0];
          steer_q <= steer_q & ~wdata[STEER_LSB +: 2];
        end
        RS_CTRL_SET: if (wdata[MODE_BIT]) mode_q <= 1'b1;
        RS_CTRL_CLR: if (wdata[MODE_BIT]) mode_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (rsel)
      RS_CTRL_SET: rdata[MODE_BIT] = mode_q;
      RS_STAT: begin
        rdata[EVT_W-1:0]         = masked;
        rdata[RAW_SHIFT +: EVT_W] = raw_q;
      end
      RS_EN_SET: begin
        rdata[EVT_W-1:0]      = en_q;
        rdata[STEER_LSB +: 2] = steer_q;
      end
      RS_SLOT: rdata[DATA_W-1] = raw_q[ERR_BIT];
      default: ;
    endcase
  end

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)))
    else $error("event lost"); // R7

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    !((acc_w || acc_r) && rsel == RS_STAT) |=> ((raw_q & $past(raw_q)) == $past(raw_q)))
    else $error("raw bit fell without access"); // R1

  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (acc_w && rsel == RS_EN_SET) |=> ((en_q & $past(wdata[EVT_W-1:0])) == $past(wdata[EVT_W-1:0])))
    else $error("enable not set"); // R3

  AST_STEER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(acc_w && (rsel == RS_EN_SET || rsel == RS_EN_CLR)) |=> $stable(steer_q))
    else $error("steering changed"); // R4
endmodule

// File: rtl/pirq_host_summary.sv
module pirq_host_summary #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_we,
  input  logic [NUM_PORTS-1:0] en_wdata,
  input  logic [NUM_PORTS-1:0] pending,
  output logic [NUM_PORTS-1:0] host_en,
  output logic                 irq_o
);
  always_ff @(posedge clk) begin
    if (rst)        host_en <= '0;
    else if (en_we) host_en <= en_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pending & host_en);
  end

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
    (host_en == '0) |=> !irq_o)
    else $error("irq with all ports masked"); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(pending) != '0))
    else $error("irq without pending port"); // R10
endmodule

// File: rtl/pirq_hub.sv
module pirq_hub
  import pirq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_we,
  input  logic                       reg_re,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_PORTS*EVT_W-1:0] evt_in,
  output logic                       irq_o
);
  localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int HOST_BIT = ADDR_W - 1;

  logic [OFS_W-1:0]  ofs;
  logic [PSEL_W-1:0] pidx;
  logic              host_sel;
  logic [NUM_PORTS-1:0] pending, host_en;
  logic [DATA_W-1:0] prd [NUM_PORTS];
  logic [DATA_W-1:0] rd_next;

  assign ofs      = reg_addr[OFS_W-1:0];
  assign pidx     = reg_addr[OFS_W +: PSEL_W];
  assign host_sel = reg_addr[HOST_BIT];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic psel;
    assign psel = !host_sel && (pidx == PSEL_W'(p));
    pirq_port_regs i_port (
      .clk     (clk),
      .rst     (rst),
      .sel     (psel),
      .we      (reg_we),
      .re      (reg_re),
      .ofs     (ofs),
      .wdata   (reg_wdata),
      .evt     (evt_in[p*EVT_W +: EVT_W]),
      .rdata   (prd[p]),
      .pending (pending[p])
    );
  end

  pirq_host_summary #(.NUM_PORTS(NUM_PORTS)) i_host (
    .clk      (clk),
    .rst      (rst),
    .en_we    (reg_we && host_sel && ofs == OFS_HOST_EN),
    .en_wdata (reg_wdata[NUM_PORTS-1:0]),
    .pending  (pending),
    .host_en  (host_en),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (host_sel) begin
      if (ofs == OFS_HOST_EN)      rd_next[NUM_PORTS-1:0] = host_en;
      else if (ofs == OFS_HOST_ST) rd_next[NUM_PORTS-1:0] = pending;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (pidx == PSEL_W'(p)) rd_next = prd[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_next;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && reg_rdata == '0))
    else $error("outputs not cleared by reset"); // R11
endmodule

// File: tb/test_pirq_hub.sv
module test_pirq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int EW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP*EW-1:0] evt_in = '0;
  logic        irq_o;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        chk_pend = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_hub i_pirq_hub (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_o(irq_o)
  );

  always @(posedge clk) chk_pend <= reg_re;

  always @(negedge clk) begin
    if (chk_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%08h expected=%08h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic ev(input int p, input logic [EW-1:0] b);
    evt_in[p*EW +: EW] = b;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    tests++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s: irq_o=%0b expected=%0b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_irq(1'b0, "R11 irq after reset");
    rd(16'h1008, 32'h0, "R11 status reset");
    rd(16'h1000, 32'h8, "R11 mode bit reset");
    rd(16'h8040, 32'h0, "R11 host enable reset");
    rd(16'h1010, 32'h0, "R11 enables reset");
    // R1 latch events: complete, error, set-device-bits
    ev(0, 12'h803);
    @(negedge clk);
    rd(16'h1008, 32'h0803_0000, "R1 raw latched, masked zero");
    rd(16'h8044, 32'h0, "R9 no pending with enables off");
    rd(16'h1800, 32'h8000_0000, "R8 error attention bit");
    wr(16'h1010, 32'h0000_0801);
    rd(16'h1008, 32'h0803_0801, "R2 masked and raw halves");
    rd(16'h1010, 32'h0000_0801, "R3 enable readback");
    rd(16'h8044, 32'h1, "R9 port0 pending");
    chk_irq(1'b0, "R10 masked by host enable");
    wr(16'h8040, 32'h1);
    @(negedge clk);
    chk_irq(1'b1, "R10 irq asserted");
    rd(16'h8040, 32'h1, "R10 host enable readback");
    wr(16'h1014, 32'h0000_0001);
    rd(16'h1010, 32'h0000_0800, "R3 enable clear alias");
    rd(16'h1014, 32'h0, "R3 clear alias reads zero");
    // R4 steering field
    wr(16'h1010, 32'h8000_0000);
    rd(16'h1010, 32'h8000_0800, "R4 steering loaded");
    wr(16'h1010, 32'h0000_0004);
    rd(16'h1010, 32'h8000_0804, "R4 steering kept on zero field");
    wr(16'h1014, 32'h8000_0000);
    rd(16'h1010, 32'h0000_0804, "R4 steering cleared");
    // R5 write-one acknowledge
    wr(16'h1008, 32'h0000_0800);
    rd(16'h1008, 32'h0003_0000, "R5 low-half clear");
    @(negedge clk);
    chk_irq(1'b0, "R10 irq drops after acknowledge");
    wr(16'h1008, 32'h0002_0000);
    rd(16'h1008, 32'h0001_0000, "R5 raw-half clear");
    rd(16'h1800, 32'h0, "R8 attention cleared");
    wr(16'h1008, 32'h0000_0001);
    rd(16'h1008, 32'h0, "R5 clear bit0");
    // R7 event with write clear in same cycle
    evt_in[0] = 1'b1;
    wr(16'h1008, 32'h0000_0001);
    evt_in = '0;
    rd(16'h1008, 32'h0001_0000, "R7 event beats write clear");
    // R6 clear-on-read mode
    wr(16'h1004, 32'h0000_0008);
    rd(16'h1000, 32'h0, "R5 mode bit cleared");
    wr(16'h1008, 32'h0fff_0fff);
    rd(16'h1008, 32'h0001_0000, "R6 write ignored");
    rd(16'h1008, 32'h0, "R6 read cleared bits");
    ev(0, 12'h004);
    evt_in[2] = 1'b1;
    rd(16'h1008, 32'h0004_0004, "R6 read returns bit2");
    evt_in = '0;
    rd(16'h1008, 32'h0004_0004, "R7 event beats read clear");
    rd(16'h1008, 32'h0, "R6 cleared after read");
    // Port 1 independence and host mask
    ev(1, 12'h001);
    rd(16'h3008, 32'h0001_0000, "R1 port1 raw latched");
    wr(16'h3010, 32'h0000_0001);
    rd(16'h8044, 32'h2, "R9 port1 pending only");
    rd(16'h1008, 32'h0, "R1 port0 untouched by port1 event");
    @(negedge clk);
    chk_irq(1'b0, "R10 port1 masked by host");
    wr(16'h8040, 32'h3);
    @(negedge clk);
    chk_irq(1'b1, "R10 port1 irq enabled");
    wr(16'h8040, 32'h0);
    @(negedge clk);
    chk_irq(1'b0, "R10 all ports masked");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule